// File: doc/BRIEF.md
# Countdown Alarm with Interrupt

This block is a relative alarm. Software loads a packed day/hour/minute/second count, sets a run bit, and the block subtracts one second on every pulse of a once-per-second tick input. The subtraction borrows from the next field when a field is zero. When the count steps from one second down to all-zero, a sticky pending flag sets. The counter then stays at zero.

The interrupt output is the pending flag gated by an interrupt-enable bit. Software clears the pending flag by writing one to it. A single-cycle register write port updates the four registers. A combinational read port returns the register selected by the address.

Top module: `countdown_alarm`

## Requirements
- R1: After reset the count, run bit, interrupt enable and pending flag all read zero, and `irq` is low.
- R2: Offset 0x0C holds the count: seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16, days in bits 28:21. A write stores these fields. A read returns them, and every other bit reads zero.
- R3: The count falls by exactly one second per `secTick` pulse only while bit 8 of offset 0x14 is set. With that bit clear, ticks leave the count unchanged. Offset 0x14 reads back only bit 8.
- R4: Borrow rules. When seconds are zero, seconds become 59 and minutes fall by one. When minutes are also zero, minutes become 59 and hours fall by one. When hours are also zero, hours become 23 and days fall by one.
- R5: A tick that takes the count from exactly one second to zero sets the pending flag (bit 0 of offset 0x1C). Later ticks leave the count at zero and do not wrap.
- R6: Writing zero to offset 0x0C disarms the count, and no pending flag follows.
- R7: Writing 1 to bit 0 of offset 0x1C clears the pending flag. Writing 0 there leaves it unchanged.
- R8: `irq` equals the pending flag ANDed with bit 0 of offset 0x18. The pending flag still sets while that bit is clear.
- R9: If an expiry and a clearing write to offset 0x1C fall in the same cycle, the pending flag ends up set.
- R10: The day field holds values up to 255. If a count write and a tick fall in the same cycle, the written value is kept and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Masked alarm interrupt |

## Verification
A register write or a tick takes effect at the clock edge where it is presented. The read port is combinational, so the new count, pending flag and `irq` can be seen in the cycle right after that edge. The expiry edge therefore sets the pending flag and raises `irq` together, with no added delay. The bench never drives and samples in the same cycle. Each stimulus is presented just after a rising edge and removed after the next one. The scoreboard then sets the address and samples `rdData` and `irq` on a falling edge, at least one full cycle after the edge that was meant to cause the change.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  parameter int AddrW = 5;
  parameter int DataW = 32;
  parameter int SecW  = 6;
  parameter int MinW  = 6;
  parameter int HourW = 5;
  parameter int DayW  = 8;

  localparam int SecLsb  = 0;
  localparam int MinLsb  = 8;
  localparam int HourLsb = 16;
  localparam int DayLsb  = 21;

  localparam int SecMax  = 59;
  localparam int MinMax  = 59;
  localparam int HourMax = 23;

  localparam logic [AddrW-1:0] CountAddr = AddrW'(8'h0C);
  localparam logic [AddrW-1:0] RunAddr   = AddrW'(8'h14);
  localparam logic [AddrW-1:0] IenAddr   = AddrW'(8'h18);
  localparam logic [AddrW-1:0] StatAddr  = AddrW'(8'h1C);
  localparam int RunBit  = 8;
  localparam int IenBit  = 0;
  localparam int PendBit = 0;

  typedef struct packed {
    logic [DayW-1:0]  day;
    logic [HourW-1:0] hour;
    logic [MinW-1:0]  min;
    logic [SecW-1:0]  sec;
  } countVal_t;

  typedef struct packed {
    logic loadCount;
    logic decrement;
  } alarmStrobes_t;

  function automatic longint toSeconds(countVal_t c);
    return longint'(c.sec) + 60 * longint'(c.min) + 3600 * longint'(c.hour)
         + 86400 * longint'(c.day);
  endfunction
endpackage

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  alarmStrobes_t strobes,
  input  countVal_t     loadValue,
  output countVal_t     countQ,
  output logic          expire
);
  countVal_t nextDec;
  logic      isOne;
  logic      isZero;

  always_comb begin
    isZero  = (countQ == '0);
    isOne   = (countQ.day == '0) && (countQ.hour == '0) && (countQ.min == '0)
              && (countQ.sec == SecW'(1));
    nextDec = countQ;
    if (countQ.sec != '0) begin
      nextDec.sec = countQ.sec - 1'b1;
    end else if (countQ.min != '0) begin
      nextDec.min = countQ.min - 1'b1;
      nextDec.sec = SecW'(SecMax);
    end else if (countQ.hour != '0) begin
      nextDec.hour = countQ.hour - 1'b1;
      nextDec.min  = MinW'(MinMax);
      nextDec.sec  = SecW'(SecMax);
    end else if (countQ.day != '0) begin
      nextDec.day  = countQ.day - 1'b1;
      nextDec.hour = HourW'(HourMax);
      nextDec.min  = MinW'(MinMax);
      nextDec.sec  = SecW'(SecMax);
    end
    expire = strobes.decrement && !strobes.loadCount && isOne;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobes.loadCount) begin
      countQ <= loadValue;
    end else if (strobes.decrement && !isZero) begin
      countQ <= nextDec;
    end
  end

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strobes.loadCount && !strobes.decrement) |-> $stable(countQ));

  // R4
  decrement_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.decrement && !strobes.loadCount && countQ != '0)
      |-> toSeconds(countQ) == toSeconds($past(countQ)) - 1);

  // R5
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> countQ == '0);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  input  logic             expire,
  input  countVal_t        countQ,
  output alarmStrobes_t    strobes,
  output countVal_t        loadValue,
  output logic [DataW-1:0] rdData,
  output logic             irq
);
  logic runQ;
  logic ienQ;
  logic pendQ;
  logic clrReq;

  always_comb begin
    strobes.loadCount = wrEn && (addr == CountAddr);
    strobes.decrement = secTick && runQ;
    clrReq            = wrEn && (addr == StatAddr) && wrData[PendBit];
    loadValue.sec     = wrData[SecLsb +: SecW];
    loadValue.min     = wrData[MinLsb +: MinW];
    loadValue.hour    = wrData[HourLsb +: HourW];
    loadValue.day     = wrData[DayLsb +: DayW];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      ienQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (wrEn && addr == RunAddr) runQ <= wrData[RunBit];
      if (wrEn && addr == IenAddr) ienQ <= wrData[IenBit];
      if (expire)      pendQ <= 1'b1;
      else if (clrReq) pendQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      CountAddr: begin
        rdData[SecLsb +: SecW]   = countQ.sec;
        rdData[MinLsb +: MinW]   = countQ.min;
        rdData[HourLsb +: HourW] = countQ.hour;
        rdData[DayLsb +: DayW]   = countQ.day;
      end
      RunAddr:  rdData[RunBit]  = runQ;
      IenAddr:  rdData[IenBit]  = ienQ;
      StatAddr: rdData[PendBit] = pendQ;
      default:  rdData = '0;
    endcase
    irq = pendQ & ienQ;
  end

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendQ) |-> $past(wrEn && addr == StatAddr && wrData[PendBit]));

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendQ) |-> $past(expire));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> pendQ);
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  output logic             irq
);
  alarmStrobes_t strobes;
  countVal_t     loadValue;
  countVal_t     countQ;
  logic          expire;

  alarm_regs regs_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .expire(expire), .countQ(countQ), .strobes(strobes),
    .loadValue(loadValue), .rdData(rdData), .irq(irq)
  );

  alarm_countdown count_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadValue(loadValue),
    .countQ(countQ), .expire(expire)
  );
endmodule

// File: tb/countdown_alarm_tb_top.sv
`timescale 1ns/1ps
module countdown_alarm_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  always #2.5 clk = ~clk;

  countdown_alarm dut_i (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  typedef struct {
    logic [4:0]  a;
    logic [31:0] d;
    logic        i;
    string       tag;
  } item_t;

  item_t sbq[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  // monitor: compares each queued expectation at a falling edge
  initial forever begin
    @(negedge clk);
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      nChecks++;
      if (rdData !== it.d || irq !== it.i) begin
        nFails++;
        $display("FAIL %s: addr 0x%0h rdData=0x%08h irq=%0b expected rdData=0x%08h irq=%0b",
                 it.tag, it.a, rdData, irq, it.d, it.i);
      end
    end
  end

  task automatic expectRd(logic [4:0] a, logic [31:0] d, logic i, string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.a = a; it.d = d; it.i = i; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; secTick = 1'b1;
      @(posedge clk); #1; secTick = 1'b0;
    end
  endtask

  task automatic tickWr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    secTick = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    secTick = 1'b0; wrEn = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectRd(5'h0C, 32'h0, 1'b0, "R1 count");
    expectRd(5'h14, 32'h0, 1'b0, "R1 run");
    expectRd(5'h18, 32'h0, 1'b0, "R1 ien");
    expectRd(5'h1C, 32'h0, 1'b0, "R1 pending");

    // R2 / R10 layout, unused bits dropped, day 255
    wr(5'h0C, pk(255, 23, 59, 59) | 32'hE000_C0C0);
    expectRd(5'h0C, pk(255, 23, 59, 59), 1'b0, "R2 R10 layout");

    // R3 run off: no change
    ticks(2);
    expectRd(5'h0C, pk(255, 23, 59, 59), 1'b0, "R3 halted");

    // R3 run on
    wr(5'h14, 32'h0000_0101);
    expectRd(5'h14, 32'h0000_0100, 1'b0, "R3 run readback");
    ticks(1);
    expectRd(5'h0C, pk(255, 23, 59, 58), 1'b0, "R3 one step");

    // R4 borrows
    wr(5'h0C, pk(0, 0, 1, 0)); ticks(1);
    expectRd(5'h0C, pk(0, 0, 0, 59), 1'b0, "R4 min borrow");
    wr(5'h0C, pk(0, 1, 0, 0)); ticks(1);
    expectRd(5'h0C, pk(0, 0, 59, 59), 1'b0, "R4 hour borrow");
    wr(5'h0C, pk(1, 0, 0, 0)); ticks(1);
    expectRd(5'h0C, pk(0, 23, 59, 59), 1'b0, "R4 day borrow");

    // R5 / R8 expiry while masked
    wr(5'h0C, pk(0, 0, 0, 2)); ticks(1);
    expectRd(5'h1C, 32'h0, 1'b0, "R5 not yet");
    ticks(1);
    expectRd(5'h1C, 32'h1, 1'b0, "R5 R8 pending masked");
    ticks(1);
    expectRd(5'h0C, 32'h0, 1'b0, "R5 no wrap");

    // R8 unmask
    wr(5'h18, 32'h1);
    expectRd(5'h1C, 32'h1, 1'b1, "R8 irq raised");

    // R7 clear rules
    wr(5'h1C, 32'h0);
    expectRd(5'h1C, 32'h1, 1'b1, "R7 write zero ignored");
    wr(5'h1C, 32'h1);
    expectRd(5'h1C, 32'h0, 1'b0, "R7 cleared");

    // R6 disarm
    wr(5'h0C, pk(0, 0, 0, 1));
    wr(5'h0C, 32'h0);
    ticks(2);
    expectRd(5'h1C, 32'h0, 1'b0, "R6 no pending");
    expectRd(5'h0C, 32'h0, 1'b0, "R6 count zero");

    // R9 set wins over clear
    wr(5'h0C, pk(0, 0, 0, 1)); ticks(1);
    expectRd(5'h1C, 32'h1, 1'b1, "R9 first expiry");
    wr(5'h0C, pk(0, 0, 0, 1));
    tickWr(5'h1C, 32'h1);
    expectRd(5'h1C, 32'h1, 1'b1, "R9 set wins");

    // R10 write wins over tick
    wr(5'h0C, pk(0, 0, 0, 5));
    tickWr(5'h0C, pk(0, 0, 0, 10));
    expectRd(5'h0C, pk(0, 0, 0, 10), 1'b1, "R10 write wins");

    done = 1'b1;
    summary();
  end
endmodule